// File: doc/BRIEF.md
# Register Trigger Waveform Player

This block drives a timed burst of bytes onto a single parallel-port register. A calling sequencer loads a small pair memory, in which every entry holds a byte to write and a hold time in microseconds. It then gives a start pulse with a register select and a pair count. The player writes the first byte and waits out its hold time. It repeats this for each later pair, with no idle cycles of its own between a finished hold and the next write. When the last hold has expired it reports completion with a one-cycle pulse.

Timing comes from an internal prescaler. The prescaler divides the clock down to a one-microsecond tick, and `CLK_HZ` sets the divide ratio `P = CLK_HZ / 1_000_000`. The prescaler restarts with each write, so every hold lasts exactly a whole number of microseconds. Hold times are 8-bit values, which puts the longest single wait at 255 µs.

Top module: `trig_player`

## Requirements
- R1: After a synchronous active-low reset, `busy_o`, `done_o` and `port_we_o` are all 0.
- R2: Pair k is stored with its value byte at pair-memory byte address 2k and its hold byte at address 2k+1. The player writes the values of pairs 0, 1, 2 … in that order, each as a single cycle with `port_we_o` = 1 and the value on `port_data_o`.
- R3: The gap from one write to the next is exactly 1 + d·P clock cycles, where d is the hold byte of the earlier pair.
- R4: A hold of 0 makes the next write occur on the very next clock cycle.
- R5: The largest hold, 255, gives a gap of 1 + 255·P cycles.
- R6: `done_o` is high for exactly one cycle, 1 + d·P cycles after the last write, where d is the last pair's hold. `busy_o` is low on the following cycle.
- R7: A start with a count of 0 performs no write and raises `done_o` in the cycle after the start was sampled.
- R8: A start pulse that arrives while `busy_o` is high is ignored. The running burst keeps its writes, select and timing, and only one `done_o` pulse occurs.
- R9: Every write of a burst presents on `port_sel_o` the select that was sampled with its start.
- R10: A count larger than `MAX_PAIRS` is treated as `MAX_PAIRS`.
- R11: The first write occurs in the cycle immediately after the clock edge that samples `start_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we_i | input | 1 | Pair-memory byte write enable |
| cfg_addr_i | input | $clog2(MAX_PAIRS)+1 | Pair-memory byte address (even = value, odd = hold) |
| cfg_data_i | input | 8 | Pair-memory write data |
| start_i | input | 1 | Start request, sampled while idle |
| sel_i | input | SEL_W | Target register select |
| count_i | input | $clog2(MAX_PAIRS+1) | Number of pairs to play |
| port_we_o | output | 1 | One-cycle register write strobe |
| port_sel_o | output | SEL_W | Register select of the current burst |
| port_data_o | output | 8 | Byte being written |
| busy_o | output | 1 | Burst in progress |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The bench builds the player with `CLK_HZ` = 4 MHz, which makes a microsecond four clocks long. With that setting the full 255 µs hold fits in about a thousand cycles, so the bench can measure every gap cycle-exactly, including zero holds and mixed holds. `MAX_PAIRS` = 4 keeps the memory small and lets a count of 6 exercise clamping. A 2-bit select lets each burst use a different register.

// File: rtl/trig_pkg.sv
// Shared types for the trigger waveform player.
// Assumes: nothing beyond a 2-bit encoding for four control states.
package trig_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_WRITE = 2'd1,
        ST_WAIT  = 2'd2,
        ST_DONE  = 2'd3
    } trig_state_e;
endpackage

// File: rtl/trig_prescaler.sv
// Microsecond prescaler: tick_o pulses once every DIV cycles while clr_i is low.
// Assumes: DIV >= 1; clr_i restarts the count so the first tick comes DIV cycles later.
module trig_prescaler #(
    parameter int DIV = 50
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_i,
    output logic tick_o
);
    generate
        if (DIV <= 1) begin : g_pass
            // Divide-by-one: every counting cycle is a microsecond.
            assign tick_o = ~clr_i;
        end else begin : g_div
            localparam int CW = $clog2(DIV);
            logic [CW-1:0] cnt_q;

            // Count 0..DIV-1 while enabled, restart on clear or wrap.
            always_ff @(posedge clk) begin
                if (!rst_n || clr_i)
                    cnt_q <= '0;
                else if (cnt_q == CW'(DIV - 1))
                    cnt_q <= '0;
                else
                    cnt_q <= cnt_q + 1'b1;
            end

            assign tick_o = ~clr_i && (cnt_q == CW'(DIV - 1));

            p_tick_gap_r3: assert property (@(posedge clk) disable iff (!rst_n)
                tick_o |=> !tick_o);
        end
    endgenerate
endmodule

// File: rtl/trig_pair_mem.sv
// Pair memory: byte-addressed writes, one value/hold pair read per cycle.
// Assumes: even byte address holds the value, odd holds the hold time;
// writes to pairs beyond MAX_PAIRS are dropped.
module trig_pair_mem #(
    parameter int MAX_PAIRS = 8,
    localparam int PAIR_W = (MAX_PAIRS > 1) ? $clog2(MAX_PAIRS) : 1,
    localparam int ADDR_W = PAIR_W + 1
) (
    input  logic              clk,
    input  logic              we_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [7:0]        data_i,
    input  logic [PAIR_W-1:0] rd_pair_i,
    output logic [7:0]        rd_val_o,
    output logic [7:0]        rd_dly_o
);
    logic [7:0] val_q [MAX_PAIRS];
    logic [7:0] dly_q [MAX_PAIRS];
    logic [PAIR_W-1:0] wr_pair;

    assign wr_pair = addr_i[ADDR_W-1:1];

    // Store a byte into the value or hold half of the addressed pair.
    always_ff @(posedge clk) begin
        if (we_i && (int'(wr_pair) < MAX_PAIRS)) begin
            if (addr_i[0])
                dly_q[wr_pair] <= data_i;
            else
                val_q[wr_pair] <= data_i;
        end
    end

    assign rd_val_o = val_q[rd_pair_i];
    assign rd_dly_o = dly_q[rd_pair_i];
endmodule

// File: rtl/trig_delay_cnt.sv
// Hold counter: loaded with a microsecond count, decremented on each tick.
// Assumes: ticks only arrive while a nonzero count is pending.
module trig_delay_cnt (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       load_i,
    input  logic [7:0] load_val_i,
    input  logic       tick_i,
    output logic       expire_o
);
    logic [7:0] cnt_q;

    // Load on a write cycle, otherwise count down on microsecond ticks.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (load_i)
            cnt_q <= load_val_i;
        else if (tick_i && cnt_q != 8'd0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign expire_o = tick_i && (cnt_q == 8'd1);

    p_tick_has_count_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && !load_i) |-> (cnt_q != 8'd0));
endmodule

// File: rtl/trig_player.sv
// Trigger waveform player: writes a list of value/hold pairs to one register,
// holding each value for its own microsecond count, then pulses done.
// Assumes: CLK_HZ is a whole multiple of 1 MHz; start is ignored while busy.
module trig_player
    import trig_pkg::*;
#(
    parameter int CLK_HZ    = 50_000_000,
    parameter int MAX_PAIRS = 8,
    parameter int SEL_W     = 2,
    localparam int CYC_PER_US = (CLK_HZ / 1_000_000 > 0) ? CLK_HZ / 1_000_000 : 1,
    localparam int PAIR_W = (MAX_PAIRS > 1) ? $clog2(MAX_PAIRS) : 1,
    localparam int ADDR_W = PAIR_W + 1,
    localparam int IDX_W  = $clog2(MAX_PAIRS + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we_i,
    input  logic [ADDR_W-1:0] cfg_addr_i,
    input  logic [7:0]        cfg_data_i,
    input  logic              start_i,
    input  logic [SEL_W-1:0]  sel_i,
    input  logic [IDX_W-1:0]  count_i,
    output logic              port_we_o,
    output logic [SEL_W-1:0]  port_sel_o,
    output logic [7:0]        port_data_o,
    output logic              busy_o,
    output logic              done_o
);
    trig_state_e      state_q;
    logic [IDX_W-1:0] idx_q;
    logic [IDX_W-1:0] cnt_q;
    logic [SEL_W-1:0] sel_q;
    logic [IDX_W-1:0] eff_cnt;
    logic             last_pair;
    logic [7:0]       rd_val;
    logic [7:0]       rd_dly;
    logic             us_tick;
    logic             hold_over;

    assign eff_cnt   = (count_i > IDX_W'(MAX_PAIRS)) ? IDX_W'(MAX_PAIRS) : count_i;
    assign last_pair = (IDX_W'(idx_q + 1'b1) == cnt_q);

    trig_pair_mem #(.MAX_PAIRS(MAX_PAIRS)) mem_i (
        .clk       (clk),
        .we_i      (cfg_we_i),
        .addr_i    (cfg_addr_i),
        .data_i    (cfg_data_i),
        .rd_pair_i (idx_q[PAIR_W-1:0]),
        .rd_val_o  (rd_val),
        .rd_dly_o  (rd_dly)
    );

    trig_prescaler #(.DIV(CYC_PER_US)) presc_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_i  (state_q != ST_WAIT),
        .tick_o (us_tick)
    );

    trig_delay_cnt hold_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (state_q == ST_WRITE),
        .load_val_i (rd_dly),
        .tick_i     (us_tick),
        .expire_o   (hold_over)
    );

    // Sequence control: accept start, step through pairs, finish with done.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            idx_q   <= '0;
            cnt_q   <= '0;
            sel_q   <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: if (start_i) begin
                    idx_q   <= '0;
                    cnt_q   <= eff_cnt;
                    sel_q   <= sel_i;
                    state_q <= (eff_cnt == '0) ? ST_DONE : ST_WRITE;
                end
                ST_WRITE: if (rd_dly == 8'd0) begin
                    if (last_pair) state_q <= ST_DONE;
                    else           idx_q   <= idx_q + 1'b1;
                end else begin
                    state_q <= ST_WAIT;
                end
                ST_WAIT: if (hold_over) begin
                    if (last_pair) begin
                        state_q <= ST_DONE;
                    end else begin
                        idx_q   <= idx_q + 1'b1;
                        state_q <= ST_WRITE;
                    end
                end
                ST_DONE: state_q <= ST_IDLE;
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign port_we_o   = (state_q == ST_WRITE);
    assign port_data_o = rd_val;
    assign port_sel_o  = sel_q;
    assign busy_o      = (state_q != ST_IDLE);
    assign done_o      = (state_q == ST_DONE);

    p_done_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> (!done_o && !busy_o));
    p_write_while_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
        port_we_o |-> busy_o);
    p_sel_held_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && $past(busy_o)) |-> $stable(port_sel_o));
    p_zero_count_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && start_i && count_i == '0) |=> (done_o && !port_we_o));
    p_first_write_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && start_i && count_i != '0) |=> port_we_o);
endmodule

// File: tb/trig_player_tb.sv
module trig_player_tb_top;
    localparam int P   = 4;
    localparam int MXP = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_we = 1'b0;
    logic [2:0] cfg_addr = '0;
    logic [7:0] cfg_data = '0;
    logic       start = 1'b0;
    logic [1:0] sel = '0;
    logic [2:0] count = '0;
    logic       port_we, busy, done;
    logic [1:0] port_sel;
    logic [7:0] port_data;

    trig_player #(.CLK_HZ(4_000_000), .MAX_PAIRS(MXP), .SEL_W(2)) dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_we_i(cfg_we), .cfg_addr_i(cfg_addr),
        .cfg_data_i(cfg_data), .start_i(start), .sel_i(sel), .count_i(count),
        .port_we_o(port_we), .port_sel_o(port_sel), .port_data_o(port_data),
        .busy_o(busy), .done_o(done)
    );

    always #5 clk = ~clk;

    int cyc = 0;
    int errors = 0;
    int checks = 0;
    int nwr = 0;
    int ndone = 0;
    int done_cyc = 0;
    int s_cyc = 0;
    int wr_cyc [16];
    logic [7:0] wr_dat [16];
    logic [1:0] wr_sel [16];

    always @(posedge clk) cyc <= cyc + 1;

    // Capture every write strobe and done pulse between edges.
    always @(negedge clk) begin
        if (port_we && nwr < 16) begin
            wr_cyc[nwr] = cyc; wr_dat[nwr] = port_data; wr_sel[nwr] = port_sel;
            nwr++;
        end
        if (done) begin done_cyc = cyc; ndone++; end
    end

    // Scenario table: values, holds, count, select.
    localparam logic [7:0] TV_VAL [4][4] = '{
        '{8'hA5, 8'h5A, 8'hFF, 8'h00},
        '{8'h01, 8'h02, 8'h04, 8'h08},
        '{8'h3C, 8'hC3, 8'h00, 8'h00},
        '{8'h7E, 8'h00, 8'h00, 8'h00}};
    localparam logic [7:0] TV_DLY [4][4] = '{
        '{8'd2, 8'd0, 8'd1, 8'd0},
        '{8'd0, 8'd0, 8'd0, 8'd0},
        '{8'd5, 8'd3, 8'd0, 8'd0},
        '{8'd255, 8'd0, 8'd0, 8'd0}};
    localparam int TV_CNT [4] = '{3, 4, 2, 1};
    localparam logic [1:0] TV_SEL [4] = '{2'd1, 2'd3, 2'd0, 2'd2};

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic load(input int sc);
        for (int k = 0; k < 4; k++) begin
            for (int b = 0; b < 2; b++) begin
                @(negedge clk);
                cfg_we = 1'b1; cfg_addr = 3'(2 * k + b);
                cfg_data = b ? TV_DLY[sc][k] : TV_VAL[sc][k];
            end
        end
        @(negedge clk); cfg_we = 1'b0;
    endtask

    task automatic kick(input int c, input logic [1:0] s);
        @(negedge clk);
        nwr = 0; ndone = 0;
        start = 1'b1; count = 3'(c); sel = s; s_cyc = cyc + 1;
        @(negedge clk); start = 1'b0;
    endtask

    task automatic settle();
        for (int i = 0; i < 3000 && ndone == 0; i++) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    // Compare a finished burst of n pairs from scenario sc against the rules.
    task automatic verify(input int sc, input int n, input logic [1:0] s, input string tag);
        int exp;
        exp = 0;
        chk(nwr == n, {tag, " R2 write count"}, nwr, n);
        for (int k = 0; k < n && k < nwr; k++) begin
            chk(wr_dat[k] == TV_VAL[sc][k], {tag, " R2 value"}, wr_dat[k], TV_VAL[sc][k]);
            chk(wr_sel[k] == s, {tag, " R9 select"}, wr_sel[k], s);
            chk(wr_cyc[k] - s_cyc == exp, {tag, " R3 R4 R11 write time"}, wr_cyc[k] - s_cyc, exp);
            exp += 1 + int'(TV_DLY[sc][k]) * P;
        end
        chk(ndone == 1, {tag, " R6 done pulses"}, ndone, 1);
        chk(done_cyc - s_cyc == exp, {tag, " R6 done time"}, done_cyc - s_cyc, exp);
        chk(busy == 1'b0, {tag, " R6 idle after"}, busy, 0);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    always @(posedge clk) if (cyc > 100000) begin
        errors++; checks++;
        $display("FAIL watchdog: actual=%0d expected=<100000", cyc);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(busy == 0 && done == 0 && port_we == 0, "R1 reset state",
            {busy, done, port_we}, 0);

        // Table walk (scenario 3 covers the 255 us hold, R5).
        for (int sc = 0; sc < 4; sc++) begin
            load(sc);
            kick(TV_CNT[sc], TV_SEL[sc]);
            settle();
            verify(sc, TV_CNT[sc], TV_SEL[sc], sc == 3 ? "R5 max hold" : "table");
        end

        // R7: zero count completes with no write.
        kick(0, 2'd1);
        settle();
        chk(nwr == 0, "R7 no write", nwr, 0);
        chk(ndone == 1 && done_cyc == s_cyc, "R7 done next cycle", done_cyc - s_cyc, 0);

        // R8: start while busy is ignored.
        load(2);
        kick(2, 2'd0);
        repeat (4) @(negedge clk);
        start = 1'b1; count = 3'd1; sel = 2'd3;
        @(negedge clk); start = 1'b0;
        settle();
        verify(2, 2, 2'd0, "R8 ignored start");

        // R10: count above MAX_PAIRS clamps.
        load(1);
        kick(6, 2'd2);
        settle();
        verify(1, MXP, 2'd2, "R10 clamp");

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule